// File: doc/BRIEF.md
# PCI Express Request and Completion Header Lint

This block examines the decoded fields of one PCI Express transaction header and tells whether the packet breaks any of five additional well-formedness rules. These rules sit on top of the base protocol checks. A receive path presents the header fields for one cycle with a valid strobe. One cycle later the block returns a valid pulse, a malformed flag and a one-hot-per-rule reason vector. Each reason bit names one rule, so a single header can report several violations in the same result.

The rules cover five cases. A memory request with a 4DW header whose upper address byte is zero should have used a 3DW header. Byte enables must agree with the request length. IO and configuration requests carry restrictions on traffic class, attributes and length. A completion that carries configuration-retry status must answer a configuration request. The receive path supplies that last fact on its own input. A single enable register switches all five rules on or off. It comes up on after reset.

Top module: `tlp_hdr_lint`

## Requirements
- R1: The rule enable comes up as 1 after reset. A cycle with cfgWrEn high loads cfgWrData into it at that clock edge. A header presented in that same cycle is judged with the enable value held before the write.
- R2: While the enable is 0, every header still produces an outValid pulse, but with reason all zero and malformed 0.
- R3: outValid is high exactly in the cycle after a cycle with hdrValid high. reason and malformed belong to that header and are all zero whenever outValid is 0.
- R4: reason bit 0 is set for a memory request whose hdrType is 5'b00000 or 5'b00001, whose hdrFmt bit 0 is 1 (4DW header), and whose hdrAddrHi (address bits 39:32) is 8'h00.
- R5: reason bit 1 is set for a memory, IO (hdrType 5'b00010) or configuration (hdrType 5'b00100 or 5'b00101) request whose length is not 1 DW and whose hdrFirstBe or hdrLastBe is 4'h0. A hdrLen of 0 counts as 1024 DW.
- R6: reason bit 2 is set for a memory, IO or configuration request with hdrLen equal to 1 and hdrLastBe not 4'h0.
- R7: reason bit 3 is set for an IO or configuration request with hdrTc not 0, hdrAttr not 0, or hdrLen not 1.
- R8: reason bit 4 is set for a completion (hdrType 5'b01010) whose cplStatus is 3'b010 (configuration retry) while reqWasCfg is 0. It is not set when reqWasCfg is 1 or when the status is any other value.
- R9: malformed is the OR of all reason bits. Violations of several rules are all reported together in one result.
- R10: A synchronous reset clears outValid, malformed and reason at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Load strobe for the rule enable |
| cfgWrData | input | 1 | New rule enable value |
| hdrValid | input | 1 | Header fields are valid this cycle |
| hdrFmt | input | 3 | Format field; bit 0 set means 4DW header |
| hdrType | input | 5 | Type field |
| hdrLen | input | 10 | Length in DW, 0 meaning 1024 |
| hdrTc | input | 3 | Traffic class |
| hdrAttr | input | 2 | Attribute bits |
| hdrFirstBe | input | 4 | First-DW byte enables |
| hdrLastBe | input | 4 | Last-DW byte enables |
| hdrAddrHi | input | 8 | Address bits 39:32 |
| cplStatus | input | 3 | Completion status |
| reqWasCfg | input | 1 | The request that this completion answers was a configuration request |
| outValid | output | 1 | Result valid pulse |
| malformed | output | 1 | At least one rule violated |
| reason | output | 5 | One bit per violated rule |

## Verification
The assertions assume that hdrValid is a clean single-cycle strobe sampled at clock edges. They also assume that the header fields and reqWasCfg are stable and known in any cycle where hdrValid is high. The bench changes inputs only on falling clock edges and raises hdrValid for exactly one cycle per header. It parks every field at a defined value between headers, so the rule properties never see unknown fields. The enable is written only on idle cycles, except in the one directed test that checks a write landing in the same cycle as a header.

// File: rtl/tlp_lint_pkg.sv
package tlp_lint_pkg;

  localparam int FMT_W  = 3;
  localparam int TYPE_W = 5;
  localparam int STAT_W = 3;

  localparam int RULE_ADDR4DW  = 0;
  localparam int RULE_BEMULTI  = 1;
  localparam int RULE_BESINGLE = 2;
  localparam int RULE_IOCFG    = 3;
  localparam int RULE_CRS      = 4;
  localparam int NUM_RULES     = 5;

  localparam logic [TYPE_W-1:0] TY_IO   = 5'b00010;
  localparam logic [TYPE_W-1:0] TY_CFG0 = 5'b00100;
  localparam logic [TYPE_W-1:0] TY_CFG1 = 5'b00101;
  localparam logic [TYPE_W-1:0] TY_CPL  = 5'b01010;
  localparam logic [STAT_W-1:0] ST_CRS  = 3'b010;

  typedef struct packed {
    logic load;
    logic chkOn;
  } lint_ctrl_t;

endpackage

// File: rtl/tlp_lint_ctrl.sv
module tlp_lint_ctrl
  import tlp_lint_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgWrEn,
  input  logic       cfgWrData,
  input  logic       hdrValid,
  output lint_ctrl_t strobe,
  output logic       outValid
);

  logic chkOnQ;
  logic validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      chkOnQ <= 1'b1;
      validQ <= 1'b0;
    end else begin
      validQ <= hdrValid;
      if (cfgWrEn) chkOnQ <= cfgWrData;
    end
  end

  always_comb begin
    strobe.load  = hdrValid;
    strobe.chkOn = chkOnQ;
  end

  assign outValid = validQ;

  // R1: the enable is 1 after a reset cycle
  a_r1_enable_after_reset: assert property (@(posedge clk)
    rst |=> chkOnQ);

  // R3: a result pulse never stands alone without a header the cycle before
  a_r3_valid_follows_header: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(hdrValid));

endmodule

// File: rtl/tlp_lint_dp.sv
module tlp_lint_dp
  import tlp_lint_pkg::*;
#(
  parameter int LEN_W  = 10,
  parameter int TC_W   = 3,
  parameter int ATTR_W = 2,
  parameter int BE_W   = 4,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  lint_ctrl_t           strobe,
  input  logic [FMT_W-1:0]     hdrFmt,
  input  logic [TYPE_W-1:0]    hdrType,
  input  logic [LEN_W-1:0]     hdrLen,
  input  logic [TC_W-1:0]      hdrTc,
  input  logic [ATTR_W-1:0]    hdrAttr,
  input  logic [BE_W-1:0]      hdrFirstBe,
  input  logic [BE_W-1:0]      hdrLastBe,
  input  logic [ADDR_W-1:0]    hdrAddrHi,
  input  logic [STAT_W-1:0]    cplStatus,
  input  logic                 reqWasCfg,
  output logic [NUM_RULES-1:0] reason,
  output logic                 malformed
);

  localparam logic [LEN_W-1:0] ONE_DW = LEN_W'(1);

  logic isMem, isIo, isCfg, isCpl, isReq, isIoCfg, lenOne, is4dw;
  logic [NUM_RULES-1:0] rawHits;

  always_comb begin
    isMem   = (hdrType[TYPE_W-1:1] == '0);
    isIo    = (hdrType == TY_IO);
    isCfg   = (hdrType == TY_CFG0) || (hdrType == TY_CFG1);
    isCpl   = (hdrType == TY_CPL);
    isReq   = isMem || isIo || isCfg;
    isIoCfg = isIo || isCfg;
    lenOne  = (hdrLen == ONE_DW);
    is4dw   = hdrFmt[0];

    rawHits = '0;
    rawHits[RULE_ADDR4DW]  = isMem && is4dw && (hdrAddrHi == '0);
    rawHits[RULE_BEMULTI]  = isReq && !lenOne &&
                             ((hdrFirstBe == '0) || (hdrLastBe == '0));
    rawHits[RULE_BESINGLE] = isReq && lenOne && (hdrLastBe != '0);
    rawHits[RULE_IOCFG]    = isIoCfg &&
                             ((hdrTc != '0) || (hdrAttr != '0) || !lenOne);
    rawHits[RULE_CRS]      = isCpl && (cplStatus == ST_CRS) && !reqWasCfg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reason    <= '0;
      malformed <= 1'b0;
    end else if (strobe.load && strobe.chkOn) begin
      reason    <= rawHits;
      malformed <= |rawHits;
    end else begin
      reason    <= '0;
      malformed <= 1'b0;
    end
  end

  // R2: with the rules disabled, nothing is reported
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(!strobe.chkOn) |-> (reason == '0));

  // R8: a retry status for a non-configuration request is always flagged
  a_r8_crs_flagged: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.chkOn && (hdrType == TY_CPL) &&
     (cplStatus == ST_CRS) && !reqWasCfg) |=> reason[RULE_CRS]);

  // R7: IO with nonzero traffic class is always flagged
  a_r7_io_tc_flagged: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.chkOn && (hdrType == TY_IO) && (hdrTc != '0))
    |=> reason[RULE_IOCFG]);

  // R6: single-DW and multi-DW byte-enable rules never fire together
  a_r6_be_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(reason[RULE_BEMULTI] && reason[RULE_BESINGLE]));

endmodule

// File: rtl/tlp_hdr_lint.sv
module tlp_hdr_lint
  import tlp_lint_pkg::*;
#(
  parameter int LEN_W  = 10,
  parameter int TC_W   = 3,
  parameter int ATTR_W = 2,
  parameter int BE_W   = 4,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfgWrEn,
  input  logic                 cfgWrData,
  input  logic                 hdrValid,
  input  logic [FMT_W-1:0]     hdrFmt,
  input  logic [TYPE_W-1:0]    hdrType,
  input  logic [LEN_W-1:0]     hdrLen,
  input  logic [TC_W-1:0]      hdrTc,
  input  logic [ATTR_W-1:0]    hdrAttr,
  input  logic [BE_W-1:0]      hdrFirstBe,
  input  logic [BE_W-1:0]      hdrLastBe,
  input  logic [ADDR_W-1:0]    hdrAddrHi,
  input  logic [STAT_W-1:0]    cplStatus,
  input  logic                 reqWasCfg,
  output logic                 outValid,
  output logic                 malformed,
  output logic [NUM_RULES-1:0] reason
);

  lint_ctrl_t strobe;

  tlp_lint_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .hdrValid  (hdrValid),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  tlp_lint_dp #(
    .LEN_W  (LEN_W),
    .TC_W   (TC_W),
    .ATTR_W (ATTR_W),
    .BE_W   (BE_W),
    .ADDR_W (ADDR_W)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .hdrFmt     (hdrFmt),
    .hdrType    (hdrType),
    .hdrLen     (hdrLen),
    .hdrTc      (hdrTc),
    .hdrAttr    (hdrAttr),
    .hdrFirstBe (hdrFirstBe),
    .hdrLastBe  (hdrLastBe),
    .hdrAddrHi  (hdrAddrHi),
    .cplStatus  (cplStatus),
    .reqWasCfg  (reqWasCfg),
    .reason     (reason),
    .malformed  (malformed)
  );

  // R3: no result bits outside a valid pulse
  a_r3_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (reason == '0) && !malformed);

  // R9: the flag agrees with the reason vector
  a_r9_flag_matches: assert property (@(posedge clk) disable iff (rst)
    malformed == (reason != '0));

  // R10: a reset cycle leaves the outputs cleared
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> !outValid && !malformed && (reason == '0));

endmodule

// File: tb/test_tlp_hdr_lint.sv
module test_tlp_hdr_lint;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfgWrEn, cfgWrData, hdrValid, reqWasCfg;
  logic [2:0] hdrFmt, hdrTc, cplStatus;
  logic [4:0] hdrType;
  logic [9:0] hdrLen;
  logic [1:0] hdrAttr;
  logic [3:0] hdrFirstBe, hdrLastBe;
  logic [7:0] hdrAddrHi;
  logic       outValid, malformed;
  logic [4:0] reason;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tlp_hdr_lint i_tlp_hdr_lint (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .hdrValid(hdrValid), .hdrFmt(hdrFmt), .hdrType(hdrType), .hdrLen(hdrLen),
    .hdrTc(hdrTc), .hdrAttr(hdrAttr), .hdrFirstBe(hdrFirstBe),
    .hdrLastBe(hdrLastBe), .hdrAddrHi(hdrAddrHi), .cplStatus(cplStatus),
    .reqWasCfg(reqWasCfg), .outValid(outValid), .malformed(malformed),
    .reason(reason)
  );

  typedef struct packed {
    logic [2:0] fmt;
    logic [4:0] typ;
    logic [9:0] len;
    logic [2:0] tc;
    logic [1:0] attr;
    logic [3:0] fbe;
    logic [3:0] lbe;
    logic [7:0] ahi;
    logic [2:0] st;
    logic       rcfg;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 5'h00, 10'd1, 3'd0, 2'd0, 4'hF, 4'h0, 8'h00, 3'd0, 1'b0, 5'b00000}, // R4 3DW ok
    '{3'b011, 5'h00, 10'd1, 3'd0, 2'd0, 4'hF, 4'h0, 8'h00, 3'd0, 1'b0, 5'b00001}, // R4
    '{3'b011, 5'h00, 10'd1, 3'd0, 2'd0, 4'hF, 4'h0, 8'h01, 3'd0, 1'b0, 5'b00000}, // R4 high addr
    '{3'b000, 5'h00, 10'd4, 3'd0, 2'd0, 4'hF, 4'h0, 8'h00, 3'd0, 1'b0, 5'b00010}, // R5 last 0
    '{3'b000, 5'h00, 10'd2, 3'd0, 2'd0, 4'h0, 4'hF, 8'h00, 3'd0, 1'b0, 5'b00010}, // R5 first 0
    '{3'b000, 5'h00, 10'd1, 3'd0, 2'd0, 4'hF, 4'h3, 8'h00, 3'd0, 1'b0, 5'b00100}, // R6
    '{3'b000, 5'h00, 10'd0, 3'd0, 2'd0, 4'hF, 4'hF, 8'h00, 3'd0, 1'b0, 5'b00000}, // R5 len 1024 ok
    '{3'b000, 5'h00, 10'd0, 3'd0, 2'd0, 4'hF, 4'h0, 8'h00, 3'd0, 1'b0, 5'b00010}, // R5 len 1024 bad
    '{3'b000, 5'h02, 10'd1, 3'd1, 2'd0, 4'hF, 4'h0, 8'h00, 3'd0, 1'b0, 5'b01000}, // R7 IO tc
    '{3'b010, 5'h05, 10'd2, 3'd0, 2'd0, 4'hF, 4'hF, 8'h00, 3'd0, 1'b0, 5'b01000}, // R7 cfg len
    '{3'b000, 5'h04, 10'd1, 3'd0, 2'd1, 4'hF, 4'h1, 8'h00, 3'd0, 1'b0, 5'b01100}, // R9 two rules
    '{3'b000, 5'h0A, 10'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 5'b10000}, // R8
    '{3'b000, 5'h0A, 10'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b1, 5'b00000}, // R8 cfg ok
    '{3'b010, 5'h0A, 10'd1, 3'd0, 2'd0, 4'h0, 4'h0, 8'h00, 3'd0, 1'b0, 5'b00000}, // R8 other status
    '{3'b011, 5'h00, 10'd3, 3'd0, 2'd0, 4'hF, 4'h0, 8'h00, 3'd0, 1'b0, 5'b00011}  // R9 two rules
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,flag,reason} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic park();
    hdrValid = 0; hdrFmt = 0; hdrType = 0; hdrLen = 1; hdrTc = 0; hdrAttr = 0;
    hdrFirstBe = 4'hF; hdrLastBe = 0; hdrAddrHi = 0; cplStatus = 0; reqWasCfg = 0;
  endtask

  task automatic apply(input vec_t v);
    hdrFmt = v.fmt; hdrType = v.typ; hdrLen = v.len; hdrTc = v.tc; hdrAttr = v.attr;
    hdrFirstBe = v.fbe; hdrLastBe = v.lbe; hdrAddrHi = v.ahi; cplStatus = v.st;
    reqWasCfg = v.rcfg; hdrValid = 1;
  endtask

  function automatic logic [6:0] res(input logic v, input logic [4:0] r);
    return {v, |r, r};
  endfunction

  task automatic writeEn(input logic val);
    @(negedge clk); cfgWrEn = 1; cfgWrData = val;
    @(negedge clk); cfgWrEn = 0;
  endtask

  initial begin
    rst = 1; cfgWrEn = 0; cfgWrData = 0; park();
    repeat (3) @(negedge clk);
    check("R10 reset state", {outValid, malformed, reason}, 7'b0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); apply(VECS[i]);
      @(negedge clk); park();
      check($sformatf("R4-9 vector %0d", i), {outValid, malformed, reason}, res(1'b1, VECS[i].exp));
      @(negedge clk);
      check("R3 idle after pulse", {outValid, malformed, reason}, 7'b0);
    end

    // R2: disabled rules still pulse valid with no reason
    writeEn(1'b0);
    @(negedge clk); apply(VECS[10]);
    @(negedge clk); park();
    check("R2 disabled", {outValid, malformed, reason}, res(1'b1, 5'b0));

    // R1: write in same cycle as header uses old value (0), next header uses new (1)
    @(negedge clk); apply(VECS[1]); cfgWrEn = 1; cfgWrData = 1;
    @(negedge clk); park(); cfgWrEn = 0;
    check("R1 same-cycle write uses old", {outValid, malformed, reason}, res(1'b1, 5'b0));
    @(negedge clk); apply(VECS[1]);
    @(negedge clk); park();
    check("R1 new enable in effect", {outValid, malformed, reason}, res(1'b1, 5'b00001));

    // R1: enable returns to 1 after reset
    writeEn(1'b0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk); apply(VECS[11]);
    @(negedge clk); park();
    check("R1 enable reset to 1", {outValid, malformed, reason}, res(1'b1, 5'b10000));

    // R10: reset in the header cycle suppresses the result
    @(negedge clk); apply(VECS[3]); rst = 1;
    @(negedge clk); park(); rst = 0;
    check("R10 reset clears result", {outValid, malformed, reason}, 7'b0);

    // R3: back-to-back headers each give their own result
    @(negedge clk); apply(VECS[5]);
    @(negedge clk); apply(VECS[8]);
    check("R3 back-to-back first", {outValid, malformed, reason}, res(1'b1, 5'b00100));
    @(negedge clk); park();
    check("R3 back-to-back second", {outValid, malformed, reason}, res(1'b1, 5'b01000));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule